// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block is a hardware master that loads a bitstream into a downstream FPGA through its byte-wide slave configuration port. A local source hands it configuration bytes on a valid/ready stream, with a flag that marks the final byte. A single-cycle start pulse begins a load. The block pulses the program line and waits for the target to leave initialisation. It then holds chip-select and write for the whole burst and writes one byte per configuration clock pulse. After the last byte it keeps clocking until the target reports that configuration is complete.

Every pin is a logical, active-high level: a value of 1 means the function is asserted, and any inversion needed on the board sits outside the block. Each wait has a bounded window. The three windows are initialisation, the BUSY stall on a byte, and completion. When a window runs out, the block emits a one-cycle abort strobe and returns every control pin to idle. It then reports failure on the completion strobe. When the parameter `BUSY_CHECK` is set, the block holds a byte and adds clock pulses while the target signals BUSY. When the parameter is clear, BUSY is ignored during the data burst. The target accepts back-to-back writes, so when bytes are always available the burst free-runs at one byte every three cycles.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset, prog_o, cs_o, wr_o, cclk_o, s_ready_o, abort_o and finish_o are all 0.
- R2: A start pulse raises prog_o for at least PROG_CYCLES cycles, then lowers it. cs_o stays low until init_i and busy_i are both seen at 0, and prog_o and cs_o are never 1 together.
- R3: Before the burst, cclk_o is raised while cs_o and wr_o are still 0. cs_o and wr_o then rise together, with cclk_o already high.
- R4: Each accepted byte appears on dout_o while cclk_o is high. cclk_o then goes low for one cycle and returns high, and dout_o does not change across that rising edge. With busy_i low and bytes always valid, consecutive bytes are written three cycles apart.
- R5: With BUSY_CHECK=1, busy_i high during the high phase after a byte causes one more low/high cclk_o pulse with the same byte. This repeats until busy_i is low.
- R6: With BUSY_CHECK=0, busy_i has no effect during the burst: each byte gets exactly one rising cclk_o edge.
- R7: After the byte marked by s_last_i, cs_o falls first and wr_o falls one cycle later, both with no abort.
- R8: After wr_o falls, the block pulses cclk_o until done_i is 1. It then asserts finish_o for one cycle with ok_o=1, having issued exactly as many post-burst rising edges as the target needed.
- R9: When the initialisation (INIT_TMO), BUSY (BUSY_TMO) or completion (DONE_TMO) window expires, abort_o is 1 for one cycle with all control pins at 0. On the next cycle finish_o is 1 with ok_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a load, taken only when idle |
| s_data_i | input | DW | Configuration byte from the stream |
| s_valid_i | input | 1 | Stream byte valid |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| prog_o | output | 1 | Program (configuration reset) request to the target |
| cs_o | output | 1 | Chip-select to the target |
| wr_o | output | 1 | Write-enable to the target |
| cclk_o | output | 1 | Configuration clock; the target latches on its rising edge |
| dout_o | output | DW | Configuration data bus |
| init_i | input | 1 | Target still initialising |
| busy_i | input | 1 | Target cannot take more data |
| done_i | input | 1 | Target configuration complete |
| abort_o | output | 1 | One-cycle strobe on any timeout |
| finish_o | output | 1 | One-cycle strobe at the end of a load |
| ok_o | output | 1 | Result, valid while finish_o is 1 |

## Verification
The assertions assume that the target drives init_i, busy_i and done_i as levels that change only after the pins that cause them. They also assume that start_i arrives only while the block is idle. The bench meets these assumptions with a behavioural target that updates those levels half a cycle after each rising cclk_o or program edge, and it issues start only after the previous finish. The stream source is randomised in gap pattern and content but holds s_data_i and s_last_i steady while s_valid_i waits. The BUSY stall lengths and completion delays are drawn inside the timeout windows, except in the directed tests that are meant to expire them.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_ARM,
        ST_FETCH,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_END_CS,
        ST_END_WR,
        ST_DONE_LO,
        ST_DONE_HI,
        ST_ABORT,
        ST_FINISH
    } ld_state_e;

    // Timed phases: the timer restarts whenever the phase changes
    typedef enum logic [2:0] {
        PH_NONE,
        PH_PROG,
        PH_INIT,
        PH_DATA,
        PH_DONE
    } ld_phase_e;

    typedef struct packed {
        logic prog;
        logic cs;
        logic wr;
        logic cclk;
        logic abort;
        logic finish;
    } ld_pins_t;

    function automatic ld_phase_e phase_of(ld_state_e s);
        unique case (s)
            ST_PROG:                          return PH_PROG;
            ST_WAIT_INIT:                     return PH_INIT;
            ST_CLK_LO, ST_CLK_HI:             return PH_DATA;
            ST_END_WR, ST_DONE_LO, ST_DONE_HI: return PH_DONE;
            default:                          return PH_NONE;
        endcase
    endfunction

    function automatic ld_pins_t pin_levels(ld_state_e s);
        ld_pins_t p;
        p = '0;
        unique case (s)
            ST_PROG:                          p.prog   = 1'b1;
            ST_ARM:                           p.cclk   = 1'b1;
            ST_FETCH, ST_CLK_HI:              begin p.cs = 1'b1; p.wr = 1'b1; p.cclk = 1'b1; end
            ST_CLK_LO:                        begin p.cs = 1'b1; p.wr = 1'b1; end
            ST_END_CS:                        begin p.wr = 1'b1; p.cclk = 1'b1; end
            ST_END_WR, ST_DONE_HI:            p.cclk   = 1'b1;
            ST_ABORT:                         p.abort  = 1'b1;
            ST_FINISH:                        p.finish = 1'b1;
            default:                          p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q >= limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && !expired_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cfg_byte_hold.sv
module cfg_byte_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         last_i,
    output logic [W-1:0] data_o,
    output logic         last_o
);

    logic [W-1:0] data_d, data_q;
    logic         last_d, last_q;

    always_comb begin
        data_d = data_q;
        last_d = last_q;
        if (load_i) begin
            data_d = data_i;
            last_d = last_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
            last_q <= 1'b0;
        end else begin
            data_q <= data_d;
            last_q <= last_d;
        end
    end

    assign data_o = data_q;
    assign last_o = last_q;

endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned PROG_CYCLES = 64,
    parameter int unsigned INIT_TMO    = 500000,
    parameter int unsigned BUSY_TMO    = 4096,
    parameter int unsigned DONE_TMO    = 500000,
    parameter bit          BUSY_CHECK  = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [DW-1:0] s_data_i,
    input  logic          s_valid_i,
    input  logic          s_last_i,
    output logic          s_ready_o,
    output logic          prog_o,
    output logic          cs_o,
    output logic          wr_o,
    output logic          cclk_o,
    output logic [DW-1:0] dout_o,
    input  logic          init_i,
    input  logic          busy_i,
    input  logic          done_i,
    output logic          abort_o,
    output logic          finish_o,
    output logic          ok_o
);

    localparam int unsigned LIM_A   = (PROG_CYCLES > INIT_TMO) ? PROG_CYCLES : INIT_TMO;
    localparam int unsigned LIM_B   = (BUSY_TMO > DONE_TMO) ? BUSY_TMO : DONE_TMO;
    localparam int unsigned LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int unsigned TW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        ld_state_e st;
        ld_pins_t  pins;
        logic      ok;
    } ld_regs_t;

    ld_regs_t        r_d, r_q;
    logic            tmr_clr, tmr_en, tmr_exp;
    logic [TW-1:0]   tmr_limit;
    logic            byte_load, byte_last;
    logic [DW-1:0]   byte_data;

    // Single timer shared by every timed phase; limit follows the phase
    cfg_phase_timer #(.W(TW)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tmr_clr),
        .en_i      (tmr_en),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    cfg_byte_hold #(.W(DW)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (byte_load),
        .data_i (s_data_i),
        .last_i (s_last_i),
        .data_o (byte_data),
        .last_o (byte_last)
    );

    always_comb begin
        r_d       = r_q;
        byte_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st = ST_PROG;
                    r_d.ok = 1'b0;
                end
            end
            ST_PROG: begin
                if (tmr_exp) r_d.st = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
                if (!init_i && !busy_i) r_d.st = ST_ARM;
                else if (tmr_exp)       r_d.st = ST_ABORT;
            end
            ST_ARM: begin
                r_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (s_valid_i) begin
                    byte_load = 1'b1;
                    r_d.st    = ST_CLK_LO;
                end
            end
            ST_CLK_LO: begin
                r_d.st = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (BUSY_CHECK && busy_i) begin
                    r_d.st = tmr_exp ? ST_ABORT : ST_CLK_LO;
                end else begin
                    r_d.st = byte_last ? ST_END_CS : ST_FETCH;
                end
            end
            ST_END_CS: begin
                r_d.st = ST_END_WR;
            end
            ST_END_WR, ST_DONE_HI: begin
                if (done_i) begin
                    r_d.ok = 1'b1;
                    r_d.st = ST_FINISH;
                end else if (tmr_exp) begin
                    r_d.st = ST_ABORT;
                end else begin
                    r_d.st = ST_DONE_LO;
                end
            end
            ST_DONE_LO: begin
                r_d.st = ST_DONE_HI;
            end
            ST_ABORT: begin
                r_d.ok = 1'b0;
                r_d.st = ST_FINISH;
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Pins are registered: they take the levels of the state being entered
        r_d.pins = pin_levels(r_d.st);

        tmr_en  = (phase_of(r_q.st) != PH_NONE);
        tmr_clr = (phase_of(r_d.st) != phase_of(r_q.st));
        unique case (phase_of(r_q.st))
            PH_PROG: tmr_limit = TW'(PROG_CYCLES);
            PH_INIT: tmr_limit = TW'(INIT_TMO);
            PH_DATA: tmr_limit = TW'(BUSY_TMO);
            PH_DONE: tmr_limit = TW'(DONE_TMO);
            default: tmr_limit = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st   <= ST_IDLE;
            r_q.pins <= '0;
            r_q.ok   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign s_ready_o = (r_q.st == ST_FETCH);
    assign prog_o    = r_q.pins.prog;
    assign cs_o      = r_q.pins.cs;
    assign wr_o      = r_q.pins.wr;
    assign cclk_o    = r_q.pins.cclk;
    assign abort_o   = r_q.pins.abort;
    assign finish_o  = r_q.pins.finish;
    assign ok_o      = r_q.ok;
    assign dout_o    = byte_data;

    // R2
    prog_cs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(prog_o && cs_o));

    // R3
    cs_rise_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_o) |-> (cclk_o && $past(cclk_o) && wr_o));

    // R4
    byte_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_o && $rose(cclk_o)) |-> $stable(dout_o));

    // R4
    ready_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ready_o |-> (cs_o && wr_o && cclk_o));

    // R7
    cs_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(cs_o) && !abort_o) |-> wr_o);

    // R7
    wr_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(wr_o) && !abort_o) |-> (!cs_o && !$past(cs_o)));

    // R9
    abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> (!abort_o && finish_o && !ok_o));

    // R9
    abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> !(prog_o || cs_o || wr_o || cclk_o));

endmodule

// File: tb/sim_cfg_par_loader.sv
module sim_cfg_target (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog,
    input  logic       cs,
    input  logic       wr,
    input  logic       cclk,
    input  logic [7:0] din,
    input  int         init_delay,
    input  logic       hold_init,
    input  int         busy_mod,
    input  int         busy_len,
    input  int         done_after,
    input  logic       never_done,
    output logic       init_o,
    output logic       busy_o,
    output logic       done_o
);
    logic [7:0] log [0:255];
    int n_edges, post_edges, uniq, busy_left, init_cnt;
    logic prev_cclk;

    always @(negedge clk) begin
        if (!rst_n) begin
            init_o <= 0; busy_o <= 0; done_o <= 0;
            n_edges <= 0; post_edges <= 0; uniq <= 0; busy_left <= 0; init_cnt <= 0;
        end else if (prog) begin
            init_o <= 1; busy_o <= 0; done_o <= 0;
            n_edges <= 0; post_edges <= 0; uniq <= 0; busy_left <= 0; init_cnt <= 0;
        end else begin
            if (init_o && !hold_init) begin
                if (init_cnt >= init_delay) init_o <= 0;
                else init_cnt <= init_cnt + 1;
            end
            if (cclk && !prev_cclk) begin
                if (cs && wr) begin
                    log[n_edges[7:0]] <= din;
                    n_edges <= n_edges + 1;
                    if (busy_left != 0) begin
                        busy_left <= busy_left - 1;
                        if (busy_left == 1) busy_o <= 0;
                    end else begin
                        uniq <= uniq + 1;
                        if (busy_len != 0 && ((uniq + 1) % busy_mod) == 0) begin
                            busy_o <= 1;
                            busy_left <= busy_len;
                        end
                    end
                end else if (!cs && !wr && n_edges != 0) begin
                    post_edges <= post_edges + 1;
                    if (!never_done && post_edges + 1 >= done_after) done_o <= 1;
                end
            end
        end
        prev_cclk <= cclk;
    end
endmodule

module sim_cfg_par_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5ns clk = ~clk;

    logic start0 = 0, start1 = 0, s_valid = 0, s_last = 0, sel = 0;
    logic [7:0] s_data = 0;
    int   init_delay = 0, busy_mod = 1, busy_len = 0, done_after = 1;
    logic hold_init = 0, never_done = 0;

    logic rdy0, prog0, cs0, wr0, cclk0, abort0, fin0, ok0, init0, busy0, done0;
    logic rdy1, prog1, cs1, wr1, cclk1, abort1, fin1, ok1, init1, busy1, done1;
    logic [7:0] dout0, dout1;

    cfg_par_loader #(.DW(8), .PROG_CYCLES(3), .INIT_TMO(40), .BUSY_TMO(30),
                     .DONE_TMO(60), .BUSY_CHECK(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start0), .s_data_i(s_data),
        .s_valid_i(s_valid && !sel), .s_last_i(s_last), .s_ready_o(rdy0),
        .prog_o(prog0), .cs_o(cs0), .wr_o(wr0), .cclk_o(cclk0), .dout_o(dout0),
        .init_i(init0), .busy_i(busy0), .done_i(done0),
        .abort_o(abort0), .finish_o(fin0), .ok_o(ok0));

    cfg_par_loader #(.DW(8), .PROG_CYCLES(3), .INIT_TMO(40), .BUSY_TMO(30),
                     .DONE_TMO(60), .BUSY_CHECK(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .s_data_i(s_data),
        .s_valid_i(s_valid && sel), .s_last_i(s_last), .s_ready_o(rdy1),
        .prog_o(prog1), .cs_o(cs1), .wr_o(wr1), .cclk_o(cclk1), .dout_o(dout1),
        .init_i(init1), .busy_i(busy1), .done_i(done1),
        .abort_o(abort1), .finish_o(fin1), .ok_o(ok1));

    sim_cfg_target t0 (.clk(clk), .rst_n(rst_n), .prog(prog0), .cs(cs0), .wr(wr0),
        .cclk(cclk0), .din(dout0), .init_delay(init_delay), .hold_init(hold_init),
        .busy_mod(busy_mod), .busy_len(busy_len), .done_after(done_after),
        .never_done(never_done), .init_o(init0), .busy_o(busy0), .done_o(done0));

    sim_cfg_target t1 (.clk(clk), .rst_n(rst_n), .prog(prog1), .cs(cs1), .wr(wr1),
        .cclk(cclk1), .din(dout1), .init_delay(init_delay), .hold_init(hold_init),
        .busy_mod(busy_mod), .busy_len(busy_len), .done_after(done_after),
        .never_done(never_done), .init_o(init1), .busy_o(busy1), .done_o(done1));

    logic p_prog, p_cs, p_wr, p_cclk, p_abort, p_fin, p_ok, p_rdy, p_init;
    assign p_prog  = sel ? prog1  : prog0;
    assign p_cs    = sel ? cs1    : cs0;
    assign p_wr    = sel ? wr1    : wr0;
    assign p_cclk  = sel ? cclk1  : cclk0;
    assign p_abort = sel ? abort1 : abort0;
    assign p_fin   = sel ? fin1   : fin0;
    assign p_ok    = sel ? ok1    : ok0;
    assign p_rdy   = sel ? rdy1   : rdy0;
    assign p_init  = sel ? init1  : init0;

    int n_chk = 0, n_bad = 0;

    // Monitor: cumulative counters, sampled at the falling edge
    int cyc = 0, prog_run = 0, last_prog_len = 0;
    int mon_abort = 0, v2 = 0, v3 = 0, v7 = 0, v9 = 0;
    int first_cyc = 0, last_cyc = 0;
    logic m_cs = 0, m_wr = 0, m_cclk = 0, in_burst = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (p_prog) prog_run = prog_run + 1;
            else if (prog_run != 0) begin last_prog_len = prog_run; prog_run = 0; end
            if (p_prog && p_cs) v2 = v2 + 1;
            if (p_cs && !m_cs && p_init) v2 = v2 + 1;
            if (p_cs && !m_cs && (!p_cclk || !m_cclk || !p_wr)) v3 = v3 + 1;
            if (m_cs && !p_cs && !p_abort && !p_wr) v7 = v7 + 1;
            if (m_wr && !p_wr && !p_abort && m_cs) v7 = v7 + 1;
            if (p_abort) begin
                mon_abort = mon_abort + 1;
                if (p_prog || p_cs || p_wr || p_cclk) v9 = v9 + 1;
            end
            if (p_cclk && !m_cclk && p_cs && p_wr) begin
                if (!in_burst) first_cyc = cyc;
                in_burst = 1;
                last_cyc = cyc;
            end
            if (!p_cs) in_burst = 0;
        end
        m_cs = p_cs; m_wr = p_wr; m_cclk = p_cclk;
    end

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_load(input string req, input bit use1, input int nb, input int idly,
                            input bit hinit, input int bmod, input int blen, input int dafter,
                            input bit ndone, input bit gaps, input bit exp_ok);
        logic [7:0] src [0:63];
        logic [7:0] exp_log [0:255];
        int a0, s2, s3, s7, s9, idx, guard, nexp, bad, edges, post;
        bit vdrv, rdy_seen, got, okv;
        sel = use1;
        init_delay = idly; hold_init = hinit; busy_mod = bmod; busy_len = blen;
        done_after = dafter; never_done = ndone;
        for (int i = 0; i < nb; i++) src[i] = 8'($urandom);
        a0 = mon_abort; s2 = v2; s3 = v3; s7 = v7; s9 = v9;
        @(negedge clk);
        if (use1) start1 = 1; else start0 = 1;
        @(negedge clk);
        start0 = 0; start1 = 0;
        idx = 0; vdrv = 0; rdy_seen = 0; got = 0; okv = 0; guard = 0;
        while (!got && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (vdrv && rdy_seen) idx++;
            if (idx < nb && (!gaps || ($urandom % 4) != 0)) begin
                s_valid = 1; s_data = src[idx]; s_last = (idx == nb - 1); vdrv = 1;
            end else begin
                s_valid = 0; vdrv = 0;
            end
            rdy_seen = p_rdy;
            if (p_fin) begin got = 1; okv = p_ok; end
        end
        s_valid = 0;
        chk(got, "R8 finish strobe seen", int'(got), 1);
        chk(okv == exp_ok, exp_ok ? "R8 ok flag" : "R9 failure flag", int'(okv), int'(exp_ok));
        chk(mon_abort - a0 == (exp_ok ? 0 : 1), "R9 abort pulse count", mon_abort - a0, exp_ok ? 0 : 1);
        chk(v2 == s2 && last_prog_len >= 3, "R2 program pulse and init wait", v2 - s2, 0);
        chk(v3 == s3, "R3 clock parked high before select", v3 - s3, 0);
        chk(v7 == s7, "R7 select released before write", v7 - s7, 0);
        chk(v9 == s9, "R9 pins idle during abort", v9 - s9, 0);
        edges = use1 ? t1.n_edges : t0.n_edges;
        post  = use1 ? t1.post_edges : t0.post_edges;
        if (hinit) chk(edges == 0, "R9 no data after init timeout", edges, 0);
        if (exp_ok) begin
            nexp = 0;
            for (int i = 0; i < nb; i++) begin
                exp_log[nexp] = src[i]; nexp++;
                if (!use1 && blen != 0 && ((i + 1) % bmod) == 0)
                    for (int j = 0; j < blen; j++) begin exp_log[nexp] = src[i]; nexp++; end
            end
            chk(edges == nexp, req, edges, nexp);
            bad = 0;
            for (int k = 0; k < nexp && k < edges; k++)
                if ((use1 ? t1.log[k] : t0.log[k]) != exp_log[k]) bad++;
            chk(bad == 0, req, bad, 0);
            chk(post == dafter, "R8 completion pulses", post, dafter);
            if (!gaps && (use1 || blen == 0))
                chk(last_cyc - first_cyc == 3 * (nb - 1), "R4 free-run byte spacing",
                    last_cyc - first_cyc, 3 * (nb - 1));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c0f));
        repeat (4) @(negedge clk);
        chk(!(prog0 | cs0 | wr0 | cclk0 | rdy0 | abort0 | fin0), "R1 idle during reset", 0, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk({prog0, cs0, wr0, cclk0} == 4'b0 && {prog1, cs1, wr1, cclk1} == 4'b0,
            "R1 pins idle after reset", int'({prog0, cs0, wr0, cclk0}), 0);
        chk(!rdy0 && !abort0 && !fin0, "R1 strobes idle after reset",
            int'({rdy0, abort0, fin0}), 0);
        // Directed: free-running burst, no stall (R3, R4, R7, R8)
        run_load("R4 byte log plain", 0, 8, 5, 0, 1, 0, 3, 0, 0, 1);
        // Stall on every third byte (R5)
        run_load("R5 byte log with stalls", 0, 9, 2, 0, 3, 2, 4, 0, 1, 1);
        // Stall on the final byte (R5, R7)
        run_load("R5 stall on last byte", 0, 4, 0, 0, 4, 3, 1, 0, 0, 1);
        // Single-byte bitstream
        run_load("R4 single byte", 0, 1, 0, 0, 1, 0, 1, 0, 0, 1);
        // BUSY ignored with checking disabled (R6)
        run_load("R6 busy ignored", 1, 6, 3, 0, 1, 3, 2, 0, 0, 1);
        // Random loads within all windows
        for (int n = 0; n < 8; n++)
            run_load("R5 random load", 0, 1 + int'($urandom % 20), int'($urandom % 16), 0,
                     1 + int'($urandom % 5), int'($urandom % 5), 1 + int'($urandom % 10),
                     0, 1, 1);
        // Timeouts (R9)
        run_load("R9 init timeout", 0, 4, 0, 1, 1, 0, 1, 0, 0, 0);
        run_load("R9 busy timeout", 0, 6, 0, 0, 2, 40, 1, 0, 0, 0);
        run_load("R9 done timeout", 0, 3, 0, 0, 1, 0, 1, 1, 0, 0);
        // Recovery after failures
        run_load("R4 load after abort", 0, 5, 1, 0, 1, 0, 2, 0, 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule